// File: doc/BRIEF.md
# Memory Access Rights Checker

This block decides, for one memory access at a time, whether the access may go ahead. Each access arrives with a domain number, a 2-bit access-permission code for the page being touched, the privilege level of the requester and whether it is a read or a write. A 32-bit domain control word holds one 2-bit mode for each of sixteen domains. Two global control bits, a system bit and a ROM bit, change what the permission code 00 allows. A translation-fault input from the page walker takes part in ranking the faults, so that the block reports a single outcome per access.

The verdict is combinational in the same cycle: grant, domain fault or permission fault. When a data access aborts, a status register, a domain register and an address register record the fault on the next clock edge. Instruction-fetch aborts and accesses that are granted leave those registers alone. The surrounding exception logic reads the registers directly.

Top module: `acc_guard`

## Requirements
- R1: After reset the fault status, fault domain and fault address registers all read zero.
- R2: A domain whose mode field is 00 (no access) or 10 (reserved) gives a domain fault and no grant, whatever the permission code and control bits are.
- R3: A domain whose mode field is 11 (manager) grants every access, whatever the permission code and control bits are, and never gives a permission fault.
- R4: In a client domain (mode 01), permission code 01 lets only privileged accesses through, for read or write. Code 10 adds user reads. Code 11 lets everything through. A denied access gives a permission fault.
- R5: In a client domain with permission code 00, system=0 and ROM=0 deny everything. system=1 and ROM=0 allow only privileged reads. system=0 and ROM=1 allow reads at either privilege level. Both bits set denies everything. A denied access gives a permission fault.
- R6: At most one of translation, domain and permission fault is reported for an access, ranked translation first, then domain, then permission. A translation fault clears both the domain and the permission fault outputs and the grant.
- R7: On the clock edge after a valid data access that faults, the status register takes 0101 for a translation fault, 1001 for a domain fault or 1101 for a permission fault. The domain register takes the access's domain number and the address register takes its virtual address.
- R8: An instruction-fetch access that faults, and any access that is granted, leave all three fault registers unchanged.
- R9: With the valid input low, grant and both fault outputs are low and the fault registers do not change.
- R10: Domain n takes its mode from bits 2n+1:2n of the domain control word. The fields of other domains have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| chk_valid | input | 1 | An access is presented this cycle |
| chk_data | input | 1 | 1 = data access, 0 = instruction fetch |
| chk_priv | input | 1 | 1 = privileged requester, 0 = user |
| chk_write | input | 1 | 1 = write, 0 = read |
| xlat_fault | input | 1 | Page walk found no mapping |
| dom_num | input | 4 | Domain of the translated page |
| ap_code | input | 2 | Access-permission code of the page |
| dom_ctrl | input | 32 | Sixteen 2-bit domain modes |
| sys_bit | input | 1 | System control bit |
| rom_bit | input | 1 | ROM control bit |
| vaddr | input | 32 | Virtual address of the access |
| grant | output | 1 | Access may proceed |
| dom_fault | output | 1 | Domain fault reported |
| perm_fault | output | 1 | Permission fault reported |
| fault_status | output | 4 | Captured fault status code |
| fault_domain | output | 4 | Captured domain number |
| fault_addr | output | 32 | Captured faulting virtual address |

## Verification
Grant and the two fault outputs are combinational, so they are due in the same cycle as the inputs. The bench drives each access on a falling edge and reads the verdict a few nanoseconds later, before the next rising edge. The three fault registers are due one rising edge later. The bench reads them 1 ns after that edge, while the access is still held, and compares them with a model that it updates only for faulting data accesses. It drops valid on the next falling edge, so each access is captured exactly once.

// File: rtl/acc_guard_pkg.sv
package acc_guard_pkg;

   typedef enum logic [1:0] {
      DM_BLOCKED = 2'b00,
      DM_CLIENT  = 2'b01,
      DM_RSVD    = 2'b10,
      DM_OWNER   = 2'b11
   } dom_mode_e;

   typedef enum logic [1:0] {
      FK_NONE = 2'd0,
      FK_XLAT = 2'd1,
      FK_DOM  = 2'd2,
      FK_PERM = 2'd3
   } fault_kind_e;

   typedef struct packed {
      logic rd_priv;
      logic wr_priv;
      logic rd_user;
      logic wr_user;
   } rights_t;

   localparam int unsigned FS_W = 4;
   localparam logic [FS_W-1:0] FS_XLAT = 4'b0101;
   localparam logic [FS_W-1:0] FS_DOM  = 4'b1001;
   localparam logic [FS_W-1:0] FS_PERM = 4'b1101;

   function automatic logic [FS_W-1:0] kind_to_code(fault_kind_e k);
      case (k)
         FK_XLAT: return FS_XLAT;
         FK_DOM:  return FS_DOM;
         FK_PERM: return FS_PERM;
         default: return '0;
      endcase
   endfunction

endpackage

// File: rtl/dom_mode_sel.sv
module dom_mode_sel
   import acc_guard_pkg::*;
#(
   parameter int unsigned NUM_DOM = 16,
   localparam int unsigned DOM_W = $clog2(NUM_DOM),
   localparam int unsigned CTRL_W = 2 * NUM_DOM
) (
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic [DOM_W-1:0]  dom_idx,
   output dom_mode_e         mode
);

   logic [1:0] field [NUM_DOM];

   generate
      if (NUM_DOM < 2 || (1 << DOM_W) != NUM_DOM) begin : g_bad_count
         $error("dom_mode_sel: NUM_DOM must be a power of two, at least 2");
      end
      for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
         assign field[g] = ctrl_word[2*g +: 2];
      end
   endgenerate

   assign mode = dom_mode_e'(field[dom_idx]);

endmodule

// File: rtl/ap_rights.sv
module ap_rights
   import acc_guard_pkg::*;
(
   input  logic [1:0] ap,
   input  logic       sys_bit,
   input  logic       rom_bit,
   output rights_t    rights
);

   always_comb begin
      rights = '0;
      case (ap)
         2'b00: begin
            case ({sys_bit, rom_bit})
               2'b10:   rights.rd_priv = 1'b1;
               2'b01: begin
                  rights.rd_priv = 1'b1;
                  rights.rd_user = 1'b1;
               end
               default: rights = '0;
            endcase
         end
         2'b01: begin
            rights.rd_priv = 1'b1;
            rights.wr_priv = 1'b1;
         end
         2'b10: begin
            rights.rd_priv = 1'b1;
            rights.wr_priv = 1'b1;
            rights.rd_user = 1'b1;
         end
         default: rights = '1;
      endcase
   end

   // R4
   always_comb begin
      user_implies_priv_chk: assert (!((rights.rd_user && !rights.rd_priv) ||
                                       (rights.wr_user && !rights.wr_priv)))
         else $error("user right without privileged right");
   end

endmodule

// File: rtl/fault_rank.sv
module fault_rank
   import acc_guard_pkg::*;
(
   input  logic        xlat,
   input  dom_mode_e   mode,
   input  rights_t     rights,
   input  logic        priv,
   input  logic        write,
   output fault_kind_e kind
);

   logic allowed;
   logic dom_bad;

   always_comb begin
      case ({priv, write})
         2'b10:   allowed = rights.rd_priv;
         2'b11:   allowed = rights.wr_priv;
         2'b00:   allowed = rights.rd_user;
         default: allowed = rights.wr_user;
      endcase
   end

   assign dom_bad = (mode == DM_BLOCKED) || (mode == DM_RSVD);

   always_comb begin
      if (xlat)                                  kind = FK_XLAT;
      else if (dom_bad)                          kind = FK_DOM;
      else if (mode == DM_CLIENT && !allowed)    kind = FK_PERM;
      else                                       kind = FK_NONE;
   end

endmodule

// File: rtl/fault_log.sv
module fault_log
   import acc_guard_pkg::*;
#(
   parameter int unsigned VA_W  = 32,
   parameter int unsigned DOM_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              valid,
   input  logic              is_data,
   input  fault_kind_e       kind,
   input  logic [DOM_W-1:0]  dom_idx,
   input  logic [VA_W-1:0]   va,
   output logic [FS_W-1:0]   status_q,
   output logic [DOM_W-1:0]  domain_q,
   output logic [VA_W-1:0]   addr_q
);

   logic capture;

   assign capture = valid && is_data && (kind != FK_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status_q <= '0;
         domain_q <= '0;
         addr_q   <= '0;
      end else if (capture) begin
         status_q <= kind_to_code(kind);
         domain_q <= dom_idx;
         addr_q   <= va;
      end
   end

   // R7
   capture_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && is_data && kind != FK_NONE) |=> (addr_q == $past(va) && domain_q == $past(dom_idx)))
      else $error("fault address or domain not captured");

   // R8
   fetch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && !is_data) |=> ($stable(addr_q) && $stable(status_q) && $stable(domain_q)))
      else $error("fetch abort changed fault registers");

endmodule

// File: rtl/acc_guard.sv
module acc_guard
   import acc_guard_pkg::*;
#(
   parameter int unsigned NUM_DOM = 16,
   parameter int unsigned VA_W    = 32,
   localparam int unsigned DOM_W  = $clog2(NUM_DOM),
   localparam int unsigned CTRL_W = 2 * NUM_DOM
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              chk_valid,
   input  logic              chk_data,
   input  logic              chk_priv,
   input  logic              chk_write,
   input  logic              xlat_fault,
   input  logic [DOM_W-1:0]  dom_num,
   input  logic [1:0]        ap_code,
   input  logic [CTRL_W-1:0] dom_ctrl,
   input  logic              sys_bit,
   input  logic              rom_bit,
   input  logic [VA_W-1:0]   vaddr,
   output logic              grant,
   output logic              dom_fault,
   output logic              perm_fault,
   output logic [FS_W-1:0]   fault_status,
   output logic [DOM_W-1:0]  fault_domain,
   output logic [VA_W-1:0]   fault_addr
);

   generate
      if (VA_W < 12) begin : g_bad_va
         $error("acc_guard: VA_W too small");
      end
   endgenerate

   dom_mode_e   mode;
   rights_t     rights;
   fault_kind_e kind;

   dom_mode_sel #(.NUM_DOM(NUM_DOM)) u_sel (
      .ctrl_word (dom_ctrl),
      .dom_idx   (dom_num),
      .mode      (mode)
   );

   ap_rights u_rights (
      .ap      (ap_code),
      .sys_bit (sys_bit),
      .rom_bit (rom_bit),
      .rights  (rights)
   );

   fault_rank u_rank (
      .xlat   (xlat_fault),
      .mode   (mode),
      .rights (rights),
      .priv   (chk_priv),
      .write  (chk_write),
      .kind   (kind)
   );

   fault_log #(.VA_W(VA_W), .DOM_W(DOM_W)) u_log (
      .clk      (clk),
      .rst_n    (rst_n),
      .valid    (chk_valid),
      .is_data  (chk_data),
      .kind     (kind),
      .dom_idx  (dom_num),
      .va       (vaddr),
      .status_q (fault_status),
      .domain_q (fault_domain),
      .addr_q   (fault_addr)
   );

   assign grant      = chk_valid && (kind == FK_NONE);
   assign dom_fault  = chk_valid && (kind == FK_DOM);
   assign perm_fault = chk_valid && (kind == FK_PERM);

   // R6
   single_outcome_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({grant, dom_fault, perm_fault, chk_valid && xlat_fault}))
      else $error("more than one outcome reported");

   // R3
   owner_no_perm_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (chk_valid && mode == DM_OWNER && !xlat_fault) |-> (grant && !perm_fault))
      else $error("manager domain not granted");

   // R9
   idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !chk_valid |=> ($stable(fault_status) && $stable(fault_addr)))
      else $error("fault registers moved while idle");

endmodule

// File: tb/acc_guard_test.sv
module acc_guard_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        chk_valid = 1'b0, chk_data = 1'b0, chk_priv = 1'b0, chk_write = 1'b0;
   logic        xlat_fault = 1'b0;
   logic [3:0]  dom_num = '0;
   logic [1:0]  ap_code = '0;
   logic [31:0] dom_ctrl = '0;
   logic        sys_bit = 1'b0, rom_bit = 1'b0;
   logic [31:0] vaddr = '0;
   logic        grant, dom_fault, perm_fault;
   logic [3:0]  fault_status, fault_domain;
   logic [31:0] fault_addr;

   int n_vec = 0;
   int n_bad = 0;
   bit finished = 0;

   logic [3:0]  m_fs = '0, m_fd = '0;
   logic [31:0] m_fa = '0;

   always #5 clk = ~clk;

   acc_guard uut (
      .clk(clk), .rst_n(rst_n), .chk_valid(chk_valid), .chk_data(chk_data),
      .chk_priv(chk_priv), .chk_write(chk_write), .xlat_fault(xlat_fault),
      .dom_num(dom_num), .ap_code(ap_code), .dom_ctrl(dom_ctrl),
      .sys_bit(sys_bit), .rom_bit(rom_bit), .vaddr(vaddr),
      .grant(grant), .dom_fault(dom_fault), .perm_fault(perm_fault),
      .fault_status(fault_status), .fault_domain(fault_domain), .fault_addr(fault_addr)
   );

   // {mode, ap, sys, rom, priv, write, xlat, data, exp_grant, exp_dom, exp_perm}
   localparam int NV = 24;
   localparam logic [12:0] VEC [NV] = '{
      13'b00_11_0_0_1_0_0_1_0_1_0,  // R2 blocked
      13'b10_11_0_0_1_0_0_1_0_1_0,  // R2 reserved
      13'b11_00_0_0_0_1_0_1_1_0_0,  // R3
      13'b11_01_1_1_0_1_0_1_1_0_0,  // R3
      13'b01_01_0_0_1_1_0_1_1_0_0,  // R4
      13'b01_01_0_0_0_0_0_1_0_0_1,  // R4
      13'b01_10_0_0_0_0_0_1_1_0_0,  // R4
      13'b01_10_0_0_0_1_0_1_0_0_1,  // R4
      13'b01_10_0_0_1_1_0_0_1_0_0,  // R4
      13'b01_11_0_0_0_1_0_1_1_0_0,  // R4
      13'b01_00_0_0_1_0_0_1_0_0_1,  // R5
      13'b01_00_1_0_1_0_0_1_1_0_0,  // R5
      13'b01_00_1_0_1_1_0_1_0_0_1,  // R5
      13'b01_00_1_0_0_0_0_1_0_0_1,  // R5
      13'b01_00_0_1_0_0_0_1_1_0_0,  // R5
      13'b01_00_0_1_1_1_0_1_0_0_1,  // R5
      13'b01_00_1_1_1_0_0_1_0_0_1,  // R5
      13'b00_00_0_0_0_1_1_1_0_0_0,  // R6
      13'b01_00_0_0_0_1_1_1_0_0_0,  // R6
      13'b00_00_0_0_0_1_0_1_0_1_0,  // R6
      13'b00_11_0_0_1_0_0_0_0_1_0,  // R8
      13'b01_01_0_0_0_1_0_0_0_0_1,  // R8
      13'b11_00_0_0_0_0_1_1_0_0_0,  // R6
      13'b01_11_0_0_1_1_0_1_1_0_0   // R4
   };

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic fill_ctrl(int dom, logic [1:0] mode);
      for (int d = 0; d < 16; d++)
         dom_ctrl[2*d +: 2] = (d == dom) ? mode : ~mode;
   endtask

   task automatic check_regs(string req);
      check({req, " status"}, {28'd0, fault_status}, {28'd0, m_fs});
      check({req, " domain"}, {28'd0, fault_domain}, {28'd0, m_fd});
      check({req, " addr"}, fault_addr, m_fa);
   endtask

   initial begin
      #2_000_000;
      if (!finished) begin
         n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #1;
      // R1 reset state
      check_regs("R1");
      @(negedge clk) rst_n = 1'b1;

      for (int i = 0; i < NV; i++) begin
         logic [12:0] v;
         logic f;
         logic [3:0] code;
         v = VEC[i];
         @(negedge clk);
         fill_ctrl(i % 16, v[12:11]);
         dom_num    = 4'(i % 16);
         ap_code    = v[10:9];
         sys_bit    = v[8];
         rom_bit    = v[7];
         chk_priv   = v[6];
         chk_write  = v[5];
         xlat_fault = v[4];
         chk_data   = v[3];
         vaddr      = 32'hA000_0000 ^ (32'(i) * 32'h0101_0407);
         chk_valid  = 1'b1;
         #3;
         check("R2-R6 grant", {31'd0, grant}, {31'd0, v[2]});
         check("R2/R6 dom_fault", {31'd0, dom_fault}, {31'd0, v[1]});
         check("R4/R5/R6 perm_fault", {31'd0, perm_fault}, {31'd0, v[0]});
         f = v[4] | v[1] | v[0];
         code = v[4] ? 4'b0101 : (v[1] ? 4'b1001 : 4'b1101);
         if (f && v[3]) begin
            m_fs = code; m_fd = 4'(i % 16); m_fa = vaddr;
         end
         @(posedge clk);
         #1;
         check_regs(v[3] ? "R7" : "R8");
         @(negedge clk) chk_valid = 1'b0;
      end

      // R9: valid low, faulting inputs, nothing happens
      @(negedge clk);
      fill_ctrl(3, 2'b00);
      dom_num = 4'd3; xlat_fault = 1'b1; chk_data = 1'b1; vaddr = 32'hDEAD_BEEF;
      chk_valid = 1'b0;
      #3;
      check("R9 quiet", {29'd0, grant, dom_fault, perm_fault}, 32'd0);
      @(posedge clk); #1;
      check_regs("R9");

      // R10: only the selected field matters
      @(negedge clk);
      xlat_fault = 1'b0;
      dom_ctrl = '1;
      dom_ctrl[11:10] = 2'b00;
      dom_num = 4'd4; ap_code = 2'b00; sys_bit = 1'b0; rom_bit = 1'b0;
      chk_priv = 1'b0; chk_write = 1'b1; chk_data = 1'b0; chk_valid = 1'b1;
      #3;
      check("R10 neighbour granted", {31'd0, grant}, 32'd1);
      @(negedge clk);
      dom_num = 4'd5;
      #3;
      check("R10 own field faults", {31'd0, dom_fault}, 32'd1);
      @(negedge clk);
      dom_ctrl = '0;
      dom_ctrl[31:30] = 2'b11;
      dom_num = 4'd15;
      #3;
      check("R10 top field", {31'd0, grant}, 32'd1);
      @(negedge clk) chk_valid = 1'b0;

      // R8: a granted data access leaves registers alone
      @(negedge clk);
      dom_ctrl = '1; dom_num = 4'd7; chk_data = 1'b1; vaddr = 32'h1234_5678;
      chk_valid = 1'b1;
      @(posedge clk); #1;
      check_regs("R8 granted");
      @(negedge clk) chk_valid = 1'b0;

      // R1: reset clears captured state
      @(negedge clk) rst_n = 1'b0;
      m_fs = '0; m_fd = '0; m_fa = '0;
      #1;
      check_regs("R1 rereset");
      @(negedge clk) rst_n = 1'b1;

      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule